// File: doc/BRIEF.md
# Boot-Overlay Memory Select Decoder

This block produces the chip selects for the memory of a small 8-bit processor system. The processor drives its 16-bit address over an 8-bit pin bus in two halves. While the per-cycle strobe is high the pins carry the high byte, and at other times they carry the low byte. On the rising edge of that strobe the decoder captures the high byte. From the captured byte it derives one ROM select and four selects for 1 KB RAM sections. Bit 7 of the captured byte is address bit 15, and bits 3:2 are address bits 11:10.

While the run input is low the processor is held in reset. During that time a boot flag is armed that pins the ROM select on, so execution begins in ROM at 0x8000 whatever the address bits say. Boot code releases the overlay by issuing an output instruction with opcode 0x64. That instruction pulses a control line, and the decoder watches this line for a rising edge.

From then on, address bit 15 captured at each strobe chooses between ROM and RAM. An external inhibit input can suppress every RAM select at any moment. One machine cycle spans eight clocks, and the strobe occurs once in each machine cycle.

Top module: `boot_mem_select`

## Requirements
- R1: While `rst_n` is low, and after it rises until the boot flag is released, `rom_sel` is 1 and `ram_sel` is 0, whatever address byte the strobes capture. Reset clears `hi_addr` to 0.
- R2: At the first clock edge that sees `addr_strobe` high after it was low, `hi_addr` takes the value of `addr_pins`. This happens in both the boot phase and the run phase. At every other edge `hi_addr` keeps its value.
- R3: A rising edge on `boot_release` clears the boot flag. `rom_sel` stays 1 until the next strobe capture. Only reset arms the flag again, so further pulses change nothing.
- R4: Once the boot flag is clear, each strobe capture loads `rom_sel` with pin bit 7 (address bit 15): 1 selects ROM and 0 selects RAM.
- R5: When `rom_sel` is 0 and `ram_inhibit` is 0, `ram_sel` is one-hot, with bit k set where k is captured pin bits 3:2 (address bits 11:10).
- R6: While `ram_inhibit` is 1, `ram_sel` is 0 in the same cycle, and `rom_sel` and `hi_addr` are not affected.
- R7: At most one of `rom_sel` and the four `ram_sel` bits is 1 at any time.
- R8: A strobe held high over several edges captures only once. Pin changes while it stays high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | processor clock |
| rst_n | input | 1 | run level; low holds reset (asynchronous) |
| addr_pins | input | 8 | multiplexed address pins |
| addr_strobe | input | 1 | high-byte capture strobe, once per machine cycle |
| boot_release | input | 1 | output-instruction pulse that ends the boot overlay |
| ram_inhibit | input | 1 | external RAM inhibit, active high |
| rom_sel | output | 1 | ROM chip select |
| ram_sel | output | 4 | one-hot 1 KB RAM section selects |
| hi_addr | output | 8 | captured high address byte; bits 3:0 are address bits 11:8 |

## Verification
Captures are driven during boot with bit 15 clear and a bank-3 pattern. Because the bench expects `rom_sel` to stay 1, a decoder that ignores the boot flag is caught. Bit 15 set and clear are then captured after release, and all four values of bits 11:10 are walked, so the ROM/RAM choice and every section select are checked.

The inhibit is raised and dropped between captures to show that it masks combinationally and stores nothing. A strobe held high while the pins change separates edge capture from level capture. A second reset shows that the overlay re-arms.

// File: rtl/boot_mem_select_pkg.sv
package boot_mem_select_pkg;

  typedef enum logic [0:0] {
    PH_BOOT = 1'b0,
    PH_RUN  = 1'b1
  } boot_phase_e;

  // Number of bits needed to index n items (at least 1).
  function automatic int idx_width(input int n);
    int w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction

  // Selects for one RAM section are allowed only with ROM off and no inhibit.
  function automatic logic ram_allowed(input logic rom_active, input logic inhibit);
    return !rom_active && !inhibit;
  endfunction

endpackage

// File: rtl/rise_detect.sv
module rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_in;
  end

  assign rise = level_in && !prev_q;

  p_single_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise)
    else $error("p_single_rise_r8: rise asserted two cycles in a row");
endmodule

// File: rtl/boot_overlay_ctrl.sv
module boot_overlay_ctrl
  import boot_mem_select_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic release_rise,
  output logic boot_active
);
  boot_phase_e phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            phase_q <= PH_BOOT;
    else if (release_rise) phase_q <= PH_RUN;
  end

  assign boot_active = (phase_q == PH_BOOT);

  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    release_rise |=> !boot_active)
    else $error("p_release_r3: boot flag still set after release pulse");

  p_no_rearm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_active |=> !boot_active)
    else $error("p_no_rearm_r3: boot flag re-armed without reset");
endmodule

// File: rtl/high_addr_latch.sv
module high_addr_latch #(
  parameter int ADDR_W  = 8,
  parameter int ROM_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pins,
  input  logic              capture,
  input  logic              force_rom,
  output logic [ADDR_W-1:0] hi_q,
  output logic              rom_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_q <= '0;
    else if (capture) hi_q <= pins;
  end

  // ROM latch: held set by the boot flag, otherwise follows bit 15 at capture.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rom_q <= 1'b1;
    else if (force_rom) rom_q <= 1'b1;
    else if (capture)   rom_q <= pins[ROM_BIT];
  end

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> hi_q == $past(pins))
    else $error("p_capture_r2: high byte not captured");

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(hi_q))
    else $error("p_hold_r2: high byte changed without capture");

  p_rom_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !force_rom) |=> rom_q == $past(pins[ROM_BIT]))
    else $error("p_rom_bit_r4: rom latch did not take bit 15");

  p_boot_forces_r1: assert property (@(posedge clk) disable iff (!rst_n)
    force_rom |=> rom_q)
    else $error("p_boot_forces_r1: rom latch not held during boot");
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
  import boot_mem_select_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int BANK_W = idx_width(BANKS)
) (
  input  logic [BANK_W-1:0] bank_idx,
  input  logic              rom_active,
  input  logic              inhibit,
  output logic [BANKS-1:0]  sel
);
  logic enable;
  assign enable = ram_allowed(rom_active, inhibit);

  for (genvar k = 0; k < BANKS; k++) begin : g_sect
    assign sel[k] = enable && (bank_idx == BANK_W'(k));
  end

  always_comb begin
    p_inhibit_r6: assert (!inhibit || sel == '0)
      else $error("p_inhibit_r6: RAM selected while inhibited");
    p_onehot_r5: assert (!enable || $onehot(sel))
      else $error("p_onehot_r5: enabled RAM select not one-hot");
  end
endmodule

// File: rtl/boot_mem_select.sv
module boot_mem_select
  import boot_mem_select_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int ROM_BIT  = 7,
  parameter int BANKS    = 4,
  parameter int BANK_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_pins,
  input  logic              addr_strobe,
  input  logic              boot_release,
  input  logic              ram_inhibit,
  output logic              rom_sel,
  output logic [BANKS-1:0]  ram_sel,
  output logic [ADDR_W-1:0] hi_addr
);
  localparam int BANK_W = idx_width(BANKS);

  logic strobe_rise;
  logic release_rise;
  logic boot_active;
  logic rom_q;
  logic [BANK_W-1:0] bank_idx;

  rise_detect u_strobe_edge (
    .clk(clk), .rst_n(rst_n), .level_in(addr_strobe), .rise(strobe_rise)
  );

  rise_detect u_release_edge (
    .clk(clk), .rst_n(rst_n), .level_in(boot_release), .rise(release_rise)
  );

  boot_overlay_ctrl u_boot (
    .clk(clk), .rst_n(rst_n), .release_rise(release_rise), .boot_active(boot_active)
  );

  high_addr_latch #(.ADDR_W(ADDR_W), .ROM_BIT(ROM_BIT)) u_latch (
    .clk(clk), .rst_n(rst_n), .pins(addr_pins), .capture(strobe_rise),
    .force_rom(boot_active), .hi_q(hi_addr), .rom_q(rom_q)
  );

  assign bank_idx = hi_addr[BANK_LSB +: BANK_W];

  bank_decoder #(.BANKS(BANKS), .BANK_W(BANK_W)) u_dec (
    .bank_idx(bank_idx), .rom_active(rom_q), .inhibit(ram_inhibit), .sel(ram_sel)
  );

  assign rom_sel = rom_q;

  p_boot_rom_r1: assert property (@(posedge clk) disable iff (!rst_n)
    boot_active |-> (rom_sel && ram_sel == '0))
    else $error("p_boot_rom_r1: ROM not forced during boot");

  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_sel, ram_sel}))
    else $error("p_exclusive_r7: more than one select active");

  p_release_holds_rom_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_active && !strobe_rise) |=> rom_sel)
    else $error("p_release_holds_rom_r3: ROM dropped before a capture");
endmodule

// File: tb/boot_mem_select_bench.sv
module boot_mem_select_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr_pins = 8'h00;
  logic       addr_strobe = 1'b0;
  logic       boot_release = 1'b0;
  logic       ram_inhibit = 1'b0;
  logic       rom_sel;
  logic [3:0] ram_sel;
  logic [7:0] hi_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  boot_mem_select u_boot_mem_select (
    .clk(clk), .rst_n(rst_n), .addr_pins(addr_pins), .addr_strobe(addr_strobe),
    .boot_release(boot_release), .ram_inhibit(ram_inhibit),
    .rom_sel(rom_sel), .ram_sel(ram_sel), .hi_addr(hi_addr)
  );

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected selects from the requirements: {rom, ram[3:0], hi[7:0]}.
  function automatic logic [12:0] expect_sel(input logic rom, input logic inh, input logic [7:0] hi);
    logic [3:0] ram;
    ram = (rom || inh) ? 4'b0000 : (4'b0001 << hi[3:2]);
    return {rom, ram, hi};
  endfunction

  function automatic logic [12:0] outs();
    return {rom_sel, ram_sel, hi_addr};
  endfunction

  // One machine cycle: strobe high for one edge carrying the high byte, then low byte.
  task automatic mcycle(input logic [7:0] hi);
    @(negedge clk);
    addr_pins = hi; addr_strobe = 1'b1;
    @(negedge clk);
    addr_strobe = 1'b0; addr_pins = ~hi;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_release();
    @(negedge clk); boot_release = 1'b1;
    @(negedge clk); boot_release = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 in reset", outs(), expect_sel(1'b1, 1'b0, 8'h00));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", outs(), expect_sel(1'b1, 1'b0, 8'h00));
  endtask

  task automatic t_boot_phase();
    mcycle(8'h0C);
    check("R1 R2 boot capture bank3 bit15=0", outs(), expect_sel(1'b1, 1'b0, 8'h0C));
    mcycle(8'h01);
    check("R1 R2 boot capture", outs(), expect_sel(1'b1, 1'b0, 8'h01));
  endtask

  task automatic t_release();
    pulse_release();
    check("R3 rom held until capture", outs(), expect_sel(1'b1, 1'b0, 8'h01));
    mcycle(8'h00);
    check("R4 R5 ram bank0", outs(), expect_sel(1'b0, 1'b0, 8'h00));
  endtask

  task automatic t_banks();
    for (int b = 0; b < 4; b++) begin
      mcycle(8'(b << 2) | 8'h03);
      check("R5 bank walk", outs(), expect_sel(1'b0, 1'b0, 8'(b << 2) | 8'h03));
      check("R7 exclusive", 13'($countones({rom_sel, ram_sel})), 13'd1);
    end
    mcycle(8'h85);
    check("R4 bit15 picks rom", outs(), expect_sel(1'b1, 1'b0, 8'h85));
    mcycle(8'h7C);
    check("R4 bit15 clear picks ram", outs(), expect_sel(1'b0, 1'b0, 8'h7C));
  endtask

  task automatic t_inhibit();
    mcycle(8'h08);
    check("R5 bank2", outs(), expect_sel(1'b0, 1'b0, 8'h08));
    @(negedge clk); ram_inhibit = 1'b1; #1;
    check("R6 inhibit same cycle", outs(), expect_sel(1'b0, 1'b1, 8'h08));
    @(negedge clk);
    check("R6 inhibit held", outs(), expect_sel(1'b0, 1'b1, 8'h08));
    ram_inhibit = 1'b0; #1;
    check("R6 inhibit dropped", outs(), expect_sel(1'b0, 1'b0, 8'h08));
  endtask

  task automatic t_held_strobe();
    @(negedge clk); addr_pins = 8'h04; addr_strobe = 1'b1;
    @(negedge clk); addr_pins = 8'h8C;
    @(negedge clk); addr_pins = 8'hF0;
    @(negedge clk);
    check("R8 held strobe captures once", outs(), expect_sel(1'b0, 1'b0, 8'h04));
    addr_strobe = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 no capture on fall", outs(), expect_sel(1'b0, 1'b0, 8'h04));
  endtask

  task automatic t_repulse_and_rearm();
    pulse_release();
    check("R3 second pulse no effect", outs(), expect_sel(1'b0, 1'b0, 8'h04));
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mcycle(8'h00);
    check("R1 R3 reset re-arms overlay", outs(), expect_sel(1'b1, 1'b0, 8'h00));
  endtask

  initial begin
    t_reset();
    t_boot_phase();
    t_release();
    t_banks();
    t_inhibit();
    t_held_strobe();
    t_repulse_and_rearm();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule